// File: doc/BRIEF.md
# Background layer mosaic pixel hold

This block sits in the pixel path of one tile background layer. It applies a horizontal mosaic by sampling the incoming pixel at the start of each run and repeating that sample across a run whose length comes from a programmable 4-bit size. It also computes the vertical line used to fetch tile data. That line takes account of the mosaic vertical offset and of hires interlace, where the field bit becomes the line LSB. The block also passes the horizontal scroll value through, doubled in hires mode.

Each clock carries one output slot. In hires mode the slots alternate between the two interleaved screen halves: the above half first, then the below half, for each horizontal position. The run counter moves only on below-half slots, so a run covers twice as many output slots in hires. All three outputs come from a register, one cycle after their inputs.

Top module: `bg_mosaic_hold`

## Requirements
- R1: While rst_ni is low, pix_o, fetch_line_o and hscroll_o are all zero.
- R2: With mosaic_en_i low, pix_o equals pix_i of the previous cycle on every slot, in either mode.
- R3: A load slot at hpos_i = 0 always samples pix_i and starts a new run, even if the previous run has not ended. pix_o on that slot equals pix_i. A load slot is any slot when hires_i = 0, and a below_i = 1 slot when hires_i = 1.
- R4: With mosaic on and hires off, the run length is N = mosaic_size_i + 1. pix_o for position x equals the pixel that was input at position x − (x mod N) of the same row.
- R5: mosaic_size_i = 0 gives a run of 1, so every position passes through. mosaic_size_i = 15 gives a run of 16.
- R6: With mosaic on and hires on, sampling and the counting down of a run happen only on below_i = 1 slots. Every below_i = 0 slot outputs the sample held at that point. A run therefore covers 2·N output slots.
- R7: When hires_i and interlace_i are not both high, fetch_line_o = line_i, minus voffset_i when mosaic_en_i is high. The result wraps modulo 2^(LINE_W+1).
- R8: When hires_i and interlace_i are both high, the base fetch line is {line_i, f}. f is field_i with mosaic off and 0 with mosaic on.
- R9: With mosaic on in hires interlace, the subtracted offset is 2·voffset_i.
- R10: hscroll_o = 2·hscroll_i when hires_i is high, and hscroll_i otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hpos_i | input | HPOS_W | Horizontal position of the slot |
| pix_i | input | PIX_W | Incoming layer pixel |
| mosaic_en_i | input | 1 | Mosaic enable for this layer |
| mosaic_size_i | input | SIZE_W | Run length minus one |
| hires_i | input | 1 | Hires mode, two half slots per position |
| interlace_i | input | 1 | Interlace mode |
| field_i | input | 1 | Current interlace field |
| below_i | input | 1 | Slot belongs to the below screen half |
| line_i | input | LINE_W | Current scan line |
| voffset_i | input | VOFF_W | Mosaic vertical offset |
| hscroll_i | input | SCROLL_W | Layer horizontal scroll |
| pix_o | output | PIX_W | Mosaic-held pixel |
| fetch_line_o | output | LINE_W+1 | Adjusted tile fetch line |
| hscroll_o | output | SCROLL_W+1 | Scroll as used, doubled in hires |

## Verification
Rows of distinct pixels are driven with mosaic off to confirm that output is plain pass-through. The same rows are then driven with run lengths of 1, 3 and 16. Those three lengths tell a correct counter reload apart from an off-by-one in the size encoding. A short row followed at once by a restart at position 0 shows that a row start cuts a run that is still open. Hires rows check that the above-half slots hold the sample and never advance the run. The fetch line is tried with and without interlace, mosaic and offset, which separates the field masking from the offset doubling.

// File: rtl/mosaic_pkg.sv
package mosaic_pkg;
  localparam int unsigned SIZE_W   = 4;
  localparam int unsigned MAX_HOLD = 1 << SIZE_W;
  localparam int unsigned CNT_W    = $clog2(MAX_HOLD + 1);

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_LOAD = 2'd2
  } hold_act_e;
endpackage

// File: rtl/mosaic_hold_ctrl.sv
module mosaic_hold_ctrl
  import mosaic_pkg::*;
#(
  parameter int unsigned HPOS_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HPOS_W-1:0]   hpos_i,
  input  logic                mosaic_en_i,
  input  logic [SIZE_W-1:0]   mosaic_size_i,
  input  logic                hires_i,
  input  logic                below_i,
  output logic                capture_o,
  output logic [CNT_W-1:0]    cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic             load_slot;
  hold_act_e        act;

  // in hires only the below half advances the run
  assign load_slot = !hires_i || below_i;
  assign reload    = mosaic_en_i ? (CNT_W'(mosaic_size_i) + CNT_W'(1)) : CNT_W'(1);

  always_comb begin
    act = ACT_IDLE;
    if (load_slot) begin
      if (hpos_i == '0 || cnt_q <= CNT_W'(1)) act = ACT_LOAD;
      else                                    act = ACT_DEC;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case (act)
        ACT_LOAD: cnt_q <= reload;
        ACT_DEC:  cnt_q <= cnt_q - CNT_W'(1);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign capture_o = (act == ACT_LOAD);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/mosaic_pix_hold.sv
module mosaic_pix_hold #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             capture_i,
  input  logic             mosaic_en_i,
  output logic [PIX_W-1:0] pix_o,
  output logic [PIX_W-1:0] cap_o
);
  logic [PIX_W-1:0] cap_q;
  logic [PIX_W-1:0] pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      pix_q <= '0;
    end else begin
      if (capture_i) cap_q <= pix_i;
      pix_q <= (!mosaic_en_i || capture_i) ? pix_i : cap_q;
    end
  end

  assign pix_o = pix_q;
  assign cap_o = cap_q;
endmodule

// File: rtl/mosaic_line_adj.sv
module mosaic_line_adj #(
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned VOFF_W   = 4,
  parameter int unsigned SCROLL_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mosaic_en_i,
  input  logic                hires_i,
  input  logic                interlace_i,
  input  logic                field_i,
  input  logic [LINE_W-1:0]   line_i,
  input  logic [VOFF_W-1:0]   voffset_i,
  input  logic [SCROLL_W-1:0] hscroll_i,
  output logic [LINE_W:0]     fetch_line_o,
  output logic [SCROLL_W:0]   hscroll_o
);
  localparam int unsigned FL_W = LINE_W + 1;

  logic            hi_il;
  logic [FL_W-1:0] base;
  logic [FL_W-1:0] offs;
  logic [FL_W-1:0] line_d;
  logic [FL_W-1:0] line_q;
  logic [SCROLL_W:0] hs_d;
  logic [SCROLL_W:0] hs_q;

  assign hi_il = hires_i && interlace_i;

  always_comb begin
    base = hi_il ? {line_i, field_i & ~mosaic_en_i} : {1'b0, line_i};
    offs = FL_W'(voffset_i) << hi_il;
    line_d = mosaic_en_i ? (base - offs) : base;
    hs_d   = hires_i ? {hscroll_i, 1'b0} : {1'b0, hscroll_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      hs_q   <= '0;
    end else begin
      line_q <= line_d;
      hs_q   <= hs_d;
    end
  end

  assign fetch_line_o = line_q;
  assign hscroll_o    = hs_q;
endmodule

// File: rtl/bg_mosaic_hold.sv
module bg_mosaic_hold
  import mosaic_pkg::*;
#(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned HPOS_W   = 9,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned VOFF_W   = 4,
  parameter int unsigned SCROLL_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HPOS_W-1:0]   hpos_i,
  input  logic [PIX_W-1:0]    pix_i,
  input  logic                mosaic_en_i,
  input  logic [SIZE_W-1:0]   mosaic_size_i,
  input  logic                hires_i,
  input  logic                interlace_i,
  input  logic                field_i,
  input  logic                below_i,
  input  logic [LINE_W-1:0]   line_i,
  input  logic [VOFF_W-1:0]   voffset_i,
  input  logic [SCROLL_W-1:0] hscroll_i,
  output logic [PIX_W-1:0]    pix_o,
  output logic [LINE_W:0]     fetch_line_o,
  output logic [SCROLL_W:0]   hscroll_o
);
  logic             capture;
  logic [CNT_W-1:0] cnt_q;
  logic [PIX_W-1:0] cap_q;

  mosaic_hold_ctrl #(.HPOS_W(HPOS_W)) i_ctrl (
    .clk_i, .rst_ni, .hpos_i, .mosaic_en_i, .mosaic_size_i,
    .hires_i, .below_i,
    .capture_o (capture),
    .cnt_o     (cnt_q)
  );

  mosaic_pix_hold #(.PIX_W(PIX_W)) i_pix (
    .clk_i, .rst_ni, .pix_i,
    .capture_i   (capture),
    .mosaic_en_i,
    .pix_o,
    .cap_o       (cap_q)
  );

  mosaic_line_adj #(.LINE_W(LINE_W), .VOFF_W(VOFF_W), .SCROLL_W(SCROLL_W)) i_line (
    .clk_i, .rst_ni, .mosaic_en_i, .hires_i, .interlace_i, .field_i,
    .line_i, .voffset_i, .hscroll_i, .fetch_line_o, .hscroll_o
  );
endmodule

// File: rtl/bg_mosaic_chk.sv
module bg_mosaic_chk
  import mosaic_pkg::*;
#(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned HPOS_W   = 9,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned VOFF_W   = 4,
  parameter int unsigned SCROLL_W = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [HPOS_W-1:0]   hpos_i,
  input logic [PIX_W-1:0]    pix_i,
  input logic                mosaic_en_i,
  input logic                hires_i,
  input logic                interlace_i,
  input logic                below_i,
  input logic [LINE_W-1:0]   line_i,
  input logic [VOFF_W-1:0]   voffset_i,
  input logic [SCROLL_W-1:0] hscroll_i,
  input logic [PIX_W-1:0]    pix_o,
  input logic [LINE_W:0]     fetch_line_o,
  input logic [SCROLL_W:0]   hscroll_o,
  input logic [PIX_W-1:0]    cap_q,
  input logic [CNT_W-1:0]    cnt_q
);
  AST_PASS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mosaic_en_i |=> pix_o == $past(pix_i)); // R2
  AST_ROW_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mosaic_en_i && !hires_i && hpos_i == '0) |=> pix_o == $past(pix_i)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_HOLD)); // R5
  AST_ABOVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mosaic_en_i && hires_i && !below_i) |=> pix_o == $past(cap_q)); // R6
  AST_LINE_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mosaic_en_i && !(hires_i && interlace_i)) |=> fetch_line_o == {1'b0, $past(line_i)}); // R7
  AST_FIELD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mosaic_en_i && hires_i && interlace_i && voffset_i == '0) |=> !fetch_line_o[0]); // R8
  AST_SCROLL_DBL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hires_i |=> hscroll_o == {$past(hscroll_i), 1'b0}); // R10
endmodule

bind bg_mosaic_hold bg_mosaic_chk #(
  .PIX_W(PIX_W), .HPOS_W(HPOS_W), .LINE_W(LINE_W), .VOFF_W(VOFF_W), .SCROLL_W(SCROLL_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hpos_i(hpos_i), .pix_i(pix_i),
  .mosaic_en_i(mosaic_en_i), .hires_i(hires_i), .interlace_i(interlace_i),
  .below_i(below_i), .line_i(line_i), .voffset_i(voffset_i), .hscroll_i(hscroll_i),
  .pix_o(pix_o), .fetch_line_o(fetch_line_o), .hscroll_o(hscroll_o),
  .cap_q(cap_q), .cnt_q(cnt_q)
);

// File: tb/test_bg_mosaic_hold.sv
module test_bg_mosaic_hold;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  hpos_i = '0;
  logic [7:0]  pix_i = '0;
  logic        mosaic_en_i = 1'b0;
  logic [3:0]  mosaic_size_i = '0;
  logic        hires_i = 1'b0;
  logic        interlace_i = 1'b0;
  logic        field_i = 1'b0;
  logic        below_i = 1'b0;
  logic [8:0]  line_i = '0;
  logic [3:0]  voffset_i = '0;
  logic [9:0]  hscroll_i = '0;
  logic [7:0]  pix_o;
  logic [9:0]  fetch_line_o;
  logic [10:0] hscroll_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit         chk_pix;
    logic [7:0] pix;
    logic [9:0] line;
    logic [10:0] hs;
    string      rp;
    string      rl;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  bg_mosaic_hold i_bg_mosaic_hold (
    .clk_i(clk), .rst_ni, .hpos_i, .pix_i, .mosaic_en_i, .mosaic_size_i,
    .hires_i, .interlace_i, .field_i, .below_i, .line_i, .voffset_i,
    .hscroll_i, .pix_o, .fetch_line_o, .hscroll_o
  );

  function automatic logic [7:0] pv(int rid, int x, int half);
    return 8'((rid * 37 + x * 11 + half * 5 + 1) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares outputs 5 ns after the edge that registered the item
  always begin
    @(posedge clk);
    #5;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      if (it.chk_pix) check(pix_o == it.pix, it.rp, int'(pix_o), int'(it.pix));
      check(fetch_line_o == it.line, it.rl, int'(fetch_line_o), int'(it.line));
      check(hscroll_o == it.hs, "R10", int'(hscroll_o), int'(it.hs));
    end
  end

  task automatic slot(int x, logic [7:0] p, bit men, int enc, bit hi, bit il, bit fld,
                      bit blw, int ln, int voff, int hs, bit chk, logic [7:0] ep,
                      string rp, string rl);
    exp_t it;
    logic [9:0] base;
    @(negedge clk);
    hpos_i = 9'(x); pix_i = p; mosaic_en_i = men; mosaic_size_i = 4'(enc);
    hires_i = hi; interlace_i = il; field_i = fld; below_i = blw;
    line_i = 9'(ln); voffset_i = 4'(voff); hscroll_i = 10'(hs);
    base = (hi && il) ? {9'(ln), fld & ~men} : {1'b0, 9'(ln)};
    if (men) base = base - ((hi && il) ? 10'(voff * 2) : 10'(voff));
    it.chk_pix = chk; it.pix = ep; it.line = base;
    it.hs = hi ? 11'(hs * 2) : 11'(hs);
    it.rp = rp; it.rl = rl;
    sb.push_back(it);
  endtask

  task automatic row_lo(int rid, int n, bit men, int enc, int ln, int voff, string rp);
    for (int x = 0; x < n; x++) begin
      int g;
      g = men ? (x - x % (enc + 1)) : x;
      slot(x, pv(rid, x, 1), men, enc, 1'b0, 1'b0, 1'b1, 1'b0, ln, voff, rid * 3 + x,
           1'b1, pv(rid, g, 1), rp, "R7");
    end
  endtask

  task automatic row_hi(int rid, int n, bit men, int enc, bit il, bit fld, int ln, int voff,
                        string rl);
    int nn;
    nn = enc + 1;
    for (int x = 0; x < n; x++) begin
      int ga;
      ga = (x == 0) ? 0 : (x - 1) - ((x - 1) % nn);
      slot(x, pv(rid, x, 0), men, enc, 1'b1, il, fld, 1'b0, ln, voff, rid + x,
           !men || x > 0, men ? pv(rid, ga, 1) : pv(rid, x, 0), men ? "R6" : "R2", rl);
      slot(x, pv(rid, x, 1), men, enc, 1'b1, il, fld, 1'b1, ln, voff, rid + x,
           1'b1, men ? pv(rid, x - x % nn, 1) : pv(rid, x, 1), men ? "R6" : "R2", rl);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pix_o == 8'd0, "R1", int'(pix_o), 0);
    check(fetch_line_o == 10'd0, "R1", int'(fetch_line_o), 0);
    check(hscroll_o == 11'd0, "R1", int'(hscroll_o), 0);
    rst_ni = 1'b1;

    row_lo(1, 20, 1'b0, 2, 40, 5, "R2");        // mosaic off: pass-through
    row_lo(2, 24, 1'b1, 2, 50, 5, "R4");        // run of 3
    row_lo(3, 10, 1'b1, 0, 60, 0, "R5");        // run of 1
    row_lo(4, 40, 1'b1, 15, 2, 7, "R5");        // run of 16, line wraps
    row_lo(5, 6, 1'b1, 3, 70, 1, "R3");         // cut short mid-run
    row_lo(6, 10, 1'b1, 3, 70, 1, "R3");        // restart at position 0
    row_hi(7, 10, 1'b1, 1, 1'b1, 1'b1, 20, 3, "R9");  // field masked, offset doubled
    row_hi(8, 8, 1'b0, 1, 1'b1, 1'b1, 20, 3, "R8");   // field in LSB
    row_hi(9, 12, 1'b1, 2, 1'b0, 1'b1, 30, 4, "R7");  // no interlace: offset not doubled
    row_hi(10, 6, 1'b1, 0, 1'b1, 1'b0, 9, 0, "R8");   // field 0, no offset

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule